// File: doc/BRIEF.md
# Two-Dimensional Transfer Address Generator

This block produces the sequence of byte addresses for a rectangular transfer of 16-bit elements. Software, or a larger controller, sets a start address, an element count per row, a signed step between elements of a row, a row count and a signed step taken after the last element of each row. A rising edge on the enable input starts the walk. The consumer takes the presented address by pulsing an advance strobe, and the generator then moves to the next one.

With an element step of 2 and a row step of 2, the walk covers one contiguous buffer, as a display refresh read does. With a row step larger than the element step, the walk covers a rectangle inside a wider frame buffer. For example, a window W pixels wide at 16 bits per pixel in a 320-pixel frame uses a row step of (320 - W) * 2 + 2. In one-shot mode the generator stops after the final row. In continuous mode it reloads the start address and both counts by itself and keeps going.

Top module: `dma2d_addr_gen`

## Requirements
- R1: While reset is held and after it is released, run and done are 0 and addr is 0.
- R2: When enable goes from 0 to 1 while the generator is idle, run is 1 and addr equals startAddr one clock later.
- R3: While run is 1 and advance is 0, addr holds its value.
- R4: An advance on an element that is not the last of its row adds xModify to addr. xModify is a 16-bit two's complement value, so negative steps move downward.
- R5: An advance on the last element of a row that is not the final row adds yModify (16-bit two's complement) to addr, and the next row again holds xCount elements. A row of xCount equal to 1 steps by yModify only.
- R6: In one-shot mode (autoMode = 0), the advance on element xCount*yCount clears run and sets done in the same clock.
- R7: In continuous mode (autoMode = 1), the advance on the final element sets done and loads startAddr and both counts again, and run stays 1.
- R8: Driving doneClr to 1 clears done at the next clock. If a completion occurs in the same clock, done is set instead.
- R9: If enable is 0 when an advance occurs during a walk, run clears at that clock, addr is left unchanged and done is not set.
- R10: Holding enable at 1 after a one-shot walk ends does not start a new walk. Only a new 0-to-1 edge on enable does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Starts a walk on its rising edge; 0 stops a walk at the next advance |
| autoMode | input | 1 | 1 selects continuous restart, 0 selects one-shot |
| startAddr | input | 32 | First byte address of the walk |
| xCount | input | 16 | Elements per row, at least 1 |
| xModify | input | 16 | Signed byte step between elements of a row |
| yCount | input | 16 | Rows per walk, at least 1 |
| yModify | input | 16 | Signed byte step after the last element of a row |
| advance | input | 1 | Consumer has taken the current address |
| doneClr | input | 1 | Write-one-to-clear strobe for done |
| addr | output | 32 | Current byte address, valid while run is 1 |
| run | output | 1 | A walk is in progress |
| done | output | 1 | Sticky completion flag |

## Verification
Some properties are checked on every cycle. The address holds whenever no advance is seen. Steps inside a row equal the signed element step. Run may only start after enable and may only drop on an advance. Done may only rise on an advance and is cleared by its strobe when no completion coincides. The full address sequence depends on both counts together, so only the bench scenarios can show it: the stride at row ends, the element on which the walk ends, the reload in continuous mode, the abort at an element boundary and the need for a new enable edge. These scenarios are compared against a model held in the bench.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic load;   // take start address and both counts
    logic stepX;  // move within a row
    logic stepY;  // move to the next row
  } agenCmd_t;
endpackage

// File: rtl/dma2d_datapath.sv
module dma2d_datapath
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int MOD_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  agenCmd_t          cmd,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  xCount,
  input  logic [MOD_W-1:0]  xModify,
  input  logic [CNT_W-1:0]  yCount,
  input  logic [MOD_W-1:0]  yModify,
  output logic [ADDR_W-1:0] addr,
  output logic              xLast,
  output logic              yLast
);
  localparam int EXT_W = ADDR_W - MOD_W;

  logic [CNT_W-1:0]  xLeft;
  logic [CNT_W-1:0]  yLeft;
  logic [ADDR_W-1:0] xStep;
  logic [ADDR_W-1:0] yStep;

  assign xStep = {{EXT_W{xModify[MOD_W-1]}}, xModify};
  assign yStep = {{EXT_W{yModify[MOD_W-1]}}, yModify};
  assign xLast = (xLeft == CNT_W'(1));
  assign yLast = (yLeft == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr  <= '0;
      xLeft <= '0;
      yLeft <= '0;
    end else if (cmd.load) begin
      addr  <= startAddr;
      xLeft <= xCount;
      yLeft <= yCount;
    end else if (cmd.stepX) begin
      addr  <= addr + xStep;
      xLeft <= xLeft - CNT_W'(1);
    end else if (cmd.stepY) begin
      addr  <= addr + yStep;
      xLeft <= xCount;
      yLeft <= yLeft - CNT_W'(1);
    end
  end
endmodule

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
  import dma2d_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     autoMode,
  input  logic     advance,
  input  logic     doneClr,
  input  logic     xLast,
  input  logic     yLast,
  output agenCmd_t cmd,
  output logic     run,
  output logic     done
);
  logic enPrev;
  logic finish;
  logic stop;

  always_comb begin
    cmd    = '0;
    finish = 1'b0;
    stop   = 1'b0;
    if (run && advance) begin
      if (!enable) begin
        stop = 1'b1;                 // element boundary abort
      end else if (!xLast) begin
        cmd.stepX = 1'b1;
      end else if (!yLast) begin
        cmd.stepY = 1'b1;
      end else begin
        finish = 1'b1;
        if (autoMode) cmd.load = 1'b1;
        else          stop     = 1'b1;
      end
    end else if (!run && enable && !enPrev) begin
      cmd.load = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enPrev <= 1'b0;
      run    <= 1'b0;
      done   <= 1'b0;
    end else begin
      enPrev <= enable;
      if (stop)          run <= 1'b0;
      else if (cmd.load) run <= 1'b1;
      if (finish)        done <= 1'b1;
      else if (doneClr)  done <= 1'b0;
    end
  end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int MOD_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              autoMode,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  xCount,
  input  logic [MOD_W-1:0]  xModify,
  input  logic [CNT_W-1:0]  yCount,
  input  logic [MOD_W-1:0]  yModify,
  input  logic              advance,
  input  logic              doneClr,
  output logic [ADDR_W-1:0] addr,
  output logic              run,
  output logic              done
);
  agenCmd_t cmd;
  logic     xLast;
  logic     yLast;

  dma2d_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .autoMode(autoMode),
    .advance(advance), .doneClr(doneClr), .xLast(xLast), .yLast(yLast),
    .cmd(cmd), .run(run), .done(done)
  );

  dma2d_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MOD_W(MOD_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .startAddr(startAddr),
    .xCount(xCount), .xModify(xModify), .yCount(yCount), .yModify(yModify),
    .addr(addr), .xLast(xLast), .yLast(yLast)
  );
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int MOD_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              advance,
  input logic              doneClr,
  input logic [MOD_W-1:0]  xModify,
  input logic [ADDR_W-1:0] addr,
  input logic              run,
  input logic              done,
  input logic              xLast
);
  localparam int EXT_W = ADDR_W - MOD_W;

  a_r3_hold_without_advance: assert property (@(posedge clk) disable iff (!rstN)
    (run && !advance) |=> $stable(addr));

  a_r4_row_step: assert property (@(posedge clk) disable iff (!rstN)
    (run && advance && enable && !xLast) |=>
      addr == $past(addr) + {{EXT_W{$past(xModify[MOD_W-1])}}, $past(xModify)});

  a_r2_start_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(run) |-> $past(enable));

  a_r9_stop_on_advance: assert property (@(posedge clk) disable iff (!rstN)
    $fell(run) |-> $past(advance));

  a_r6_done_on_advance: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(run && advance));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    (doneClr && !(run && advance)) |=> !done);
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.ADDR_W(ADDR_W), .MOD_W(MOD_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .advance(advance),
  .doneClr(doneClr), .xModify(xModify), .addr(addr), .run(run),
  .done(done), .xLast(xLast)
);

// File: tb/sim_dma2d_addr_gen.sv
module sim_dma2d_addr_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        autoMode = 1'b0;
  logic [31:0] startAddr = '0;
  logic [15:0] xCount = 16'd1;
  logic [15:0] xModify = 16'd2;
  logic [15:0] yCount = 16'd1;
  logic [15:0] yModify = 16'd2;
  logic        advance = 1'b0;
  logic        doneClr = 1'b0;
  logic [31:0] addr;
  logic        run;
  logic        done;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dma2d_addr_gen u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .autoMode(autoMode),
    .startAddr(startAddr), .xCount(xCount), .xModify(xModify),
    .yCount(yCount), .yModify(yModify), .advance(advance),
    .doneClr(doneClr), .addr(addr), .run(run), .done(done)
  );

  // walk table: start, xCount, xModify, yCount, yModify
  localparam int NV = 4;
  localparam logic [31:0] vStart [NV] = '{32'h1000, 32'd1288, 32'h2000, 32'h0300};
  localparam logic [15:0] vXc    [NV] = '{16'd6, 16'd4, 16'd3, 16'd1};
  localparam logic [15:0] vXm    [NV] = '{16'd2, 16'd2, 16'hFFFE, 16'd99};
  localparam logic [15:0] vYc    [NV] = '{16'd3, 16'd3, 16'd2, 16'd4};
  localparam logic [15:0] vYm    [NV] = '{16'd2, 16'd634, 16'hFFFC, 16'd8};

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  initial begin
    #4_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] e;
    logic [31:0] held;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(run == 0 && done == 0 && addr == 0, "R1", {addr[29:0], run, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(run == 0 && done == 0 && addr == 0, "R1", {addr[29:0], run, done}, 0);

    // table walks, one-shot: R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      startAddr = vStart[v]; xCount = vXc[v]; xModify = vXm[v];
      yCount = vYc[v]; yModify = vYm[v]; autoMode = 1'b0;
      enable = 1'b1; advance = 1'b1;
      e = vStart[v];
      for (int y = 0; y < int'(vYc[v]); y++) begin
        for (int x = 0; x < int'(vXc[v]); x++) begin
          @(negedge clk);
          check(run && addr == e, (x == 0) ? "R5" : "R4", addr, e);
          e = (x < int'(vXc[v]) - 1) ? e + sx(vXm[v]) : e + sx(vYm[v]);
        end
      end
      @(negedge clk);
      check(run == 0 && done == 1, "R6", {run, done}, 2'b01);
      enable = 1'b0; advance = 1'b0; doneClr = 1'b1;
      @(negedge clk);
      doneClr = 1'b0;
      check(done == 0, "R8", done, 0);
    end

    // R2 start, R3 hold, R9 abort
    startAddr = 32'h0800; xCount = 16'd5; xModify = 16'd4;
    yCount = 16'd2; yModify = 16'd20;
    enable = 1'b1;
    @(negedge clk);
    check(run && addr == 32'h0800, "R2", addr, 32'h0800);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(addr == 32'h0800, "R3", addr, 32'h0800);
    end
    advance = 1'b1;
    @(negedge clk);
    check(addr == 32'h0804, "R4", addr, 32'h0804);
    held = addr;
    enable = 1'b0;
    @(negedge clk);
    check(run == 0 && done == 0 && addr == held, "R9", {addr[29:0], run, done},
          {held[29:0], 2'b00});
    advance = 1'b0;

    // R7 continuous reload
    startAddr = 32'h0400; xCount = 16'd2; xModify = 16'd2;
    yCount = 16'd2; yModify = 16'd10; autoMode = 1'b1;
    enable = 1'b1; advance = 1'b1;
    for (int i = 0; i < 4; i++) @(negedge clk);
    check(addr == 32'h040E, "R5", addr, 32'h040E);
    @(negedge clk);
    check(run && done && addr == 32'h0400, "R7", addr, 32'h0400);
    doneClr = 1'b1;
    @(negedge clk);
    doneClr = 1'b0;
    check(done == 0 && addr == 32'h0402 && run, "R8", {addr[30:0], done}, {31'h0402, 1'b0});
    enable = 1'b0;
    @(negedge clk);
    check(run == 0, "R9", run, 0);
    advance = 1'b0; autoMode = 1'b0;

    // R8 set wins over clear, R10 no restart with enable held
    startAddr = 32'h0050; xCount = 16'd1; yCount = 16'd1;
    enable = 1'b1; advance = 1'b1;
    @(negedge clk);
    check(run && addr == 32'h0050, "R2", addr, 32'h0050);
    doneClr = 1'b1;
    @(negedge clk);
    check(done == 1 && run == 0, "R8", done, 1);
    @(negedge clk);
    doneClr = 1'b0;
    check(done == 0, "R8", done, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(run == 0, "R10", run, 0);
    end
    enable = 1'b0; advance = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check(run == 1 && addr == 32'h0050, "R10", run, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule